// File: doc/BRIEF.md
# Multi-Domain DMA Interrupt Aggregator

This block collects interrupt requests from a set of DMA pipes and from a small group of controller-wide events. It presents them to several independent software domains (execution environments). Each domain has its own read-only source word and its own writable mask word. In both words, the low bits stand for the pipes, one bit per pipe, and bit 31 stands for the controller-wide interrupt. Each domain drives one active-high, level-sensitive interrupt line.

Pipe requests enter as levels: a pipe's flag stays high until that pipe's own status is cleared elsewhere. The block stores no pipe state. Controller-wide events enter as single-cycle pulses. Each one sets a sticky status bit, but only when its enable bit is set. Software clears status bits by writing ones to a clear register. A simple synchronous register port gives access to the status, the enables, the masks and two read-only identity words.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the global status and global enable registers read zero, every domain mask reads zero and every interrupt line is low.
- R2: Address 0x00 returns the domain count in bits 11:8. Address 0x04 returns the pipe count in bits 7:0. All other bits of both words read zero.
- R3: The source word of domain d is read at 0x40+8*d. Its bit i equals pipe_pend[i] in the same cycle. Bits 30 down to the pipe count read zero.
- R4: Bit 31 of every domain source word is high exactly while some global status bit is set and that bit's enable is also set. Clearing the enable drops bit 31 and leaves the status bit stored.
- R5: A pulse on glb_evt[k] sets global status bit k+1 at the next clock edge, but only if enable bit k+1 is set. The bit positions are 1 for bus-response error, 2 for error, 3 for empty and 4 for timer. The set bit then stays set. The global status register (0x08) is read-only.
- R6: Writing to 0x0C clears the status bits that carry a one in the write data and leaves the others unchanged. If a clear and an event reach the same bit in the same cycle, the bit stays set.
- R7: The mask word of domain d is at 0x44+8*d. Only bit 31 and bits below the pipe count are writable; every other bit reads zero.
- R8: irq_out[d] is high one clock after (source AND mask) of domain d is nonzero, and low one clock after it becomes zero.
- R9: Every domain sees the same pipe and global sources, and each domain's interrupt line depends only on its own mask.
- R10: The global enable register at 0x10 keeps only bits 4:1; all other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_pend | input | NUM_PIPES | Level pending flag of each pipe |
| glb_evt | input | 4 | Global event pulses: bus-response error, error, empty, timer |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | NUM_DOMAINS | Per-domain level interrupt line |

## Verification
On every cycle, the assertions check these rules:
- a global status bit rises only after an enabled event, and falls only after a clear that names it;
- the unused bits of each source word stay zero;
- bit 31 of each source word tracks the enabled status;
- an interrupt line is high only when the previous cycle had a masked source.

Only the bench's scenarios can show the rest:
- the register encodings and the write masking of the enable and mask registers;
- that the status register ignores writes;
- the race in which a clear and an event reach the same bit in the same cycle;
- that the domains stay independent across a full sweep of the pipe inputs under different masks.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int GLB_W = 5;
  localparam logic [GLB_W-1:0] GLB_EN_KEEP = 5'b11110;
  localparam logic [7:0] A_REV    = 8'h00;
  localparam logic [7:0] A_NPIPE  = 8'h04;
  localparam logic [7:0] A_GSTAT  = 8'h08;
  localparam logic [7:0] A_GCLR   = 8'h0C;
  localparam logic [7:0] A_GEN    = 8'h10;
  localparam logic [7:0] A_DOM    = 8'h40;
  localparam int         DOM_STEP = 8;

  // next global status: clear first, then new enabled events win
  function automatic logic [GLB_W-1:0] glb_next(input logic [GLB_W-1:0] cur,
                                                input logic [GLB_W-1:0] set,
                                                input logic [GLB_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  // bits a domain may keep in its mask word
  function automatic logic [31:0] mask_keep(input int npipes);
    return 32'h8000_0000 | ((32'h1 << npipes) - 32'h1);
  endfunction

  // byte address of a domain's source word (mask sits 4 above)
  function automatic logic [7:0] dom_addr(input int d);
    return 8'(int'(A_DOM) + DOM_STEP * d);
  endfunction
endpackage

// File: rtl/irq_glb_status.sv
module irq_glb_status
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       evt,
  input  logic             en_wr,
  input  logic             clr_wr,
  input  logic [GLB_W-1:0] wdata,
  output logic [GLB_W-1:0] status,
  output logic [GLB_W-1:0] enable,
  output logic             glb_any
);
  logic [GLB_W-1:0] evt_set;
  logic [GLB_W-1:0] clr_mask;

  assign evt_set  = {evt, 1'b0} & enable;
  assign clr_mask = clr_wr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= glb_next(status, evt_set, clr_mask);
      if (en_wr) enable <= wdata & GLB_EN_KEEP;
    end
  end

  assign glb_any = |(status & enable);

  // R5
  st_rise_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) & ~$past(evt_set)) == '0);
  // R6
  st_fall_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status)) & ~$past(clr_mask)) == '0);
  // R6
  evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((status & $past(evt_set)) == $past(evt_set)));
endmodule

// File: rtl/irq_domain_route.sv
module irq_domain_route
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] pipe_pend,
  input  logic                 glb_any,
  input  logic                 mask_wr,
  input  logic [31:0]          wdata,
  output logic [31:0]          source,
  output logic [31:0]          mask,
  output logic                 irq
);
  localparam logic [31:0] KEEP = mask_keep(NUM_PIPES);

  logic hit;

  always_comb begin
    source = '0;
    source[NUM_PIPES-1:0] = pipe_pend;
    source[31] = glb_any;
  end

  assign hit = |(source & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_wr) mask <= wdata & KEEP;
      irq <= hit;
    end
  end

  // R7
  mask_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask & ~KEEP) == '0);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES   = 6,
  parameter int NUM_DOMAINS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [7:0]                  addr,
  input  logic                        wr,
  input  logic [GLB_W-1:0]            status,
  input  logic [GLB_W-1:0]            enable,
  input  logic [NUM_DOMAINS-1:0][31:0] dom_src,
  input  logic [NUM_DOMAINS-1:0][31:0] dom_mask,
  output logic                        en_wr,
  output logic                        clr_wr,
  output logic [NUM_DOMAINS-1:0]      mask_wr,
  output logic [31:0]                 rdata
);
  localparam logic [31:0] SRC_KEEP = mask_keep(NUM_PIPES);

  assign en_wr  = wr && (addr == A_GEN);
  assign clr_wr = wr && (addr == A_GCLR);

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dec
    assign mask_wr[d] = wr && (addr == dom_addr(d) + 8'd4);
    // R3
    src_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_src[d] & ~SRC_KEEP) == '0);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_REV:   rdata[11:8] = 4'(NUM_DOMAINS);
      A_NPIPE: rdata[7:0]  = 8'(NUM_PIPES);
      A_GSTAT: rdata[GLB_W-1:0] = status;
      A_GEN:   rdata[GLB_W-1:0] = enable;
      default: rdata = '0;
    endcase
    for (int d = 0; d < NUM_DOMAINS; d++) begin
      if (addr == dom_addr(d))         rdata = dom_src[d];
      if (addr == dom_addr(d) + 8'd4)  rdata = dom_mask[d];
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES   = 6,
  parameter int NUM_DOMAINS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PIPES-1:0]   pipe_pend,
  input  logic [3:0]             glb_evt,
  input  logic [7:0]             reg_addr,
  input  logic                   reg_wr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NUM_DOMAINS-1:0] irq_out
);
  logic [GLB_W-1:0]             g_status;
  logic [GLB_W-1:0]             g_enable;
  logic                         g_any;
  logic                         en_wr;
  logic                         clr_wr;
  logic [NUM_DOMAINS-1:0]       mask_wr;
  logic [NUM_DOMAINS-1:0][31:0] dom_src;
  logic [NUM_DOMAINS-1:0][31:0] dom_mask;

  irq_glb_status u_glb (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (glb_evt),
    .en_wr   (en_wr),
    .clr_wr  (clr_wr),
    .wdata   (reg_wdata[GLB_W-1:0]),
    .status  (g_status),
    .enable  (g_enable),
    .glb_any (g_any)
  );

  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_dom
    irq_domain_route #(.NUM_PIPES(NUM_PIPES)) u_dom (
      .clk       (clk),
      .rst_n     (rst_n),
      .pipe_pend (pipe_pend),
      .glb_any   (g_any),
      .mask_wr   (mask_wr[d]),
      .wdata     (reg_wdata),
      .source    (dom_src[d]),
      .mask      (dom_mask[d]),
      .irq       (irq_out[d])
    );

    // R4
    src_glb_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dom_src[d][31] == (|(g_status & g_enable)));
    // R8
    irq_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out[d] |-> $past(|(dom_src[d] & dom_mask[d])));
  end

  irq_reg_port #(.NUM_PIPES(NUM_PIPES), .NUM_DOMAINS(NUM_DOMAINS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wr       (reg_wr),
    .status   (g_status),
    .enable   (g_enable),
    .dom_src  (dom_src),
    .dom_mask (dom_mask),
    .en_wr    (en_wr),
    .clr_wr   (clr_wr),
    .mask_wr  (mask_wr),
    .rdata    (reg_rdata)
  );
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int NP = 6;
  localparam int ND = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [NP-1:0] pipe_pend = '0;
  logic [3:0]    glb_evt = '0;
  logic [7:0]    reg_addr = '0;
  logic          reg_wr = 0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [ND-1:0] irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_aggregator #(.NUM_PIPES(NP), .NUM_DOMAINS(ND)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .pipe_pend(pipe_pend), .glb_evt(glb_evt),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  function automatic logic [7:0] src_a(int d); return 8'(8'h40 + 8 * d); endfunction
  function automatic logic [7:0] msk_a(int d); return 8'(8'h44 + 8 * d); endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] v);
    @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic pulse(logic [3:0] e);
    @(negedge clk); glb_evt = e;
    @(negedge clk); glb_evt = '0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] m [ND];
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h08, v); check("R1 gstat", v, 0);
    rd(8'h10, v); check("R1 genable", v, 0);
    for (int d = 0; d < ND; d++) begin
      rd(msk_a(d), v); check("R1 mask", v, 0);
    end
    check("R1 irq", 32'(irq_out), 0);

    // R2 identity words
    rd(8'h00, v); check("R2 domains", v, 32'(ND) << 8);
    rd(8'h04, v); check("R2 pipes", v, 32'(NP));

    // R7 writable mask bits
    wr(msk_a(1), 32'hFFFF_FFFF);
    rd(msk_a(1), v); check("R7 mask keep", v, 32'h8000_0000 | ((32'h1 << NP) - 1));
    rd(msk_a(0), v); check("R7 other domain untouched", v, 0);

    // R10 enable keep bits, status read-only
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); check("R10 enable keep", v, 32'h1E);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R5 status read-only", v, 0);
    wr(8'h10, 0);

    // R3 R8 R9 sweep of all pipe patterns with distinct masks
    m[0] = 32'h15; m[1] = 32'h2A; m[2] = 32'h3F;
    for (int d = 0; d < ND; d++) wr(msk_a(d), m[d]);
    for (int p = 0; p < (1 << NP); p++) begin
      @(negedge clk); pipe_pend = NP'(p);
      for (int d = 0; d < ND; d++) begin
        reg_addr = src_a(d); #1;
        check("R3 source", reg_rdata, 32'(p));
      end
      @(negedge clk);
      for (int d = 0; d < ND; d++)
        check("R8 R9 irq", 32'(irq_out[d]), 32'((32'(p) & m[d]) != 0));
    end
    @(negedge clk); pipe_pend = '0;
    @(negedge clk);
    check("R8 irq low", 32'(irq_out), 0);

    // R5 disabled event does nothing
    pulse(4'hF);
    rd(8'h08, v); check("R5 disabled", v, 0);
    // R5 one enable: only error bit (2) via glb_evt[1]
    wr(8'h10, 32'h04);
    pulse(4'hF);
    rd(8'h08, v); check("R5 enabled only", v, 32'h04);
    // R4 bit 31 in every domain
    for (int d = 0; d < ND; d++) begin
      rd(src_a(d), v); check("R4 src31", v, 32'h8000_0000);
    end
    // R9 only masks with bit 31 fire
    wr(msk_a(0), 32'h8000_0000);
    wr(msk_a(1), 32'h0);
    wr(msk_a(2), 32'h3F);
    @(negedge clk);
    check("R9 glb irq routing", 32'(irq_out), 32'h1);

    // R5 each event to its own bit, sticky
    wr(8'h0C, 32'h1E);
    wr(8'h10, 32'h1E);
    for (int k = 0; k < 4; k++) begin
      pulse(4'(1 << k));
      repeat (3) @(negedge clk);
      rd(8'h08, v); check("R5 per-event sticky", v, 32'h1E & ((32'h4 << k) - 32'h2));
    end

    // R6 partial clear, zeros untouched
    wr(8'h0C, 32'h0A);
    rd(8'h08, v); check("R6 partial clear", v, 32'h14);
    // R6 clear vs event on bit 2 (glb_evt[1]) same cycle
    @(negedge clk); reg_addr = 8'h0C; reg_wdata = 32'h04; reg_wr = 1; glb_evt = 4'h2;
    @(negedge clk); reg_wr = 0; glb_evt = 0;
    rd(8'h08, v); check("R6 event wins", v, 32'h14);

    // R4 disable enables: bit 31 drops, status kept
    wr(8'h10, 0);
    rd(src_a(0), v); check("R4 src31 off", v, 0);
    rd(8'h08, v); check("R4 status kept", v, 32'h14);
    @(negedge clk);
    check("R8 irq drops", 32'(irq_out), 0);

    // R6 clear everything
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, v); check("R6 full clear", v, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule